// File: doc/BRIEF.md
# Same-Address Request Hazard Gate

The gate sits on the request path between an accelerator's request generator and a memory port that may complete requests in any order. That port has three physical virtual channels and an auto-select channel the fabric may steer onto any of them. The port does not check for hazards, so the gate keeps a table of outstanding reads and writes, keyed by cache-line address. It holds back any new request that would race an earlier one to the same line, until the response that clears the conflict returns. It also forwards write fences and stalls writes behind them until the writes issued before the fence have completed.

Requests pass through combinationally on a valid/ready handshake. When the gate stalls, it drops the downstream valid and the upstream ready together, so the upstream source keeps its request in place and nothing behind it can overtake it. Responses carry only a transaction tag. The entry holding that tag is freed on the clock edge where the response is seen.

Top module: `same_addr_gate`

## Requirements
- R1: After reset the table is empty and no fence is pending. With no request present, `outValid` is low and `reqReady` equals `outReady`.
- R2: A request with no hazard appears on the downstream port in the same cycle, with its kind, address and tag unchanged. It is accepted when `outReady` is high. Kind encoding: 0 read, 1 write, 2 fence. Channel encoding: 0 auto-select, 1 to 3 physical.
- R3: A write to a line with a write outstanding is stalled until that write's response has been seen. It is then issued on the channel the earlier write used, not its own.
- R4: A read to a line with a write outstanding is stalled until that write's response has been seen. It is then issued on the channel the write used.
- R5: A write to a line with any read outstanding is stalled until every such read has responded. It is then issued on its own channel.
- R6: A read to a line whose only outstanding entries are reads passes when all of those reads and the new read share one physical channel. It stalls when any of them differs in channel, or when the new read or any of those reads uses the auto-select channel.
- R7: A fence on the auto-select channel, once issued, holds every later write, on any channel, until all writes issued before it have responded. Reads are not held.
- R8: A fence on a physical channel covers only earlier writes on that channel or on auto-select. It holds only later writes on that channel or on auto-select. Writes on other physical channels pass.
- R9: The table holds 16 entries. When it is full, reads and writes are stalled. A response frees one entry, and the stalled request can then be issued.
- R10: A response frees its entry on the clock edge where it is seen. A request that was stalled by that entry is released in the next cycle, not in the response cycle.
- R11: A fence is stalled while an earlier fence still has outstanding writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request valid |
| reqReady | output | 1 | Upstream request accepted when high with reqValid |
| reqKind | input | 2 | 0 read, 1 write, 2 fence |
| reqAddr | input | ADDR_W (26) | Cache-line address |
| reqChan | input | CHAN_W (2) | 0 auto-select, 1 to 3 physical channel |
| reqTag | input | TAG_W (8) | Transaction tag |
| outValid | output | 1 | Downstream request valid |
| outReady | input | 1 | Downstream ready |
| outKind | output | 2 | Issued kind |
| outAddr | output | ADDR_W (26) | Issued line address |
| outChan | output | CHAN_W (2) | Issued channel, possibly redirected |
| outTag | output | TAG_W (8) | Issued tag |
| rspValid | input | 1 | Response valid |
| rspTag | input | TAG_W (8) | Tag of the completing transaction |

## Verification
A table entry that is never freed shows at the ports as a request on that line, or behind a fence, that stays stalled forever. An entry freed too early shows as a conflicting request released in the same cycle as the response, or before it. Both appear at the first dependent request, so the bench aims many requests at four lines to force dependencies. A lost redirect latch shows at once on `outChan` when the held read or write is released. A wrong fence scope shows as a write on an uncovered channel that is held, or a covered one that slips through.

// File: rtl/same_addr_gate_pkg.sv
package same_addr_gate_pkg;
  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FENCE = 2'd2;

  typedef struct packed {
    logic alloc;     // claim a free entry for the request being issued
    logic armFence;  // snapshot in-scope writes behind a new fence
  } gateStrobe_t;
endpackage

// File: rtl/gate_table.sv
module gate_table
  import same_addr_gate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int CHAN_W  = 2,
  parameter int TAG_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobe_t         strobe,
  input  logic                isWrite,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [CHAN_W-1:0]   cmpChan,
  input  logic [TAG_W-1:0]    inTag,
  input  logic                rspValid,
  input  logic [TAG_W-1:0]    rspTag,
  output logic                wrHit,
  output logic [CHAN_W-1:0]   wrHitChan,
  output logic                rdHit,
  output logic                rdConflict,
  output logic                fenceBusy,
  output logic                fenceBlock,
  output logic [ENTRIES-1:0]  occupied
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CHAN_W-1:0] AUTO = '0;

  logic [ENTRIES-1:0] vld, isWr, fenced;
  logic [ENTRIES-1:0] addrEq, retire, inScope, sameChan;
  logic [ADDR_W-1:0]  entAddr [ENTRIES];
  logic [CHAN_W-1:0]  entChan [ENTRIES];
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [IDX_W-1:0]   freeIdx;
  logic [CHAN_W-1:0]  fenceChan;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign addrEq[g]   = vld[g] && (entAddr[g] == inAddr);
    assign retire[g]   = rspValid && vld[g] && (entTag[g] == rspTag);
    // auto-select may land on any physical channel, so it overlaps everything
    assign inScope[g]  = (cmpChan == AUTO) || (entChan[g] == AUTO) || (entChan[g] == cmpChan);
    assign sameChan[g] = (cmpChan != AUTO) && (entChan[g] == cmpChan);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) freeIdx = IDX_W'(i);
  end

  always_comb begin
    wrHitChan = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (addrEq[i] && isWr[i]) wrHitChan = wrHitChan | entChan[i];
  end

  assign wrHit      = |(addrEq & isWr);
  assign rdHit      = |(addrEq & ~isWr);
  assign rdConflict = |(addrEq & ~isWr & ~sameChan);
  assign fenceBusy  = |fenced;
  assign fenceBlock = fenceBusy &&
                      ((fenceChan == AUTO) || (cmpChan == AUTO) || (cmpChan == fenceChan));
  assign occupied   = vld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld       <= '0;
      fenced    <= '0;
      fenceChan <= AUTO;
    end else begin
      if (strobe.armFence) fenceChan <= cmpChan;
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.alloc && (freeIdx == IDX_W'(i))) begin
          vld[i]     <= 1'b1;
          isWr[i]    <= isWrite;
          entAddr[i] <= inAddr;
          entChan[i] <= cmpChan;
          entTag[i]  <= inTag;
          fenced[i]  <= 1'b0;
        end else if (retire[i]) begin
          vld[i]    <= 1'b0;
          fenced[i] <= 1'b0;
        end else if (strobe.armFence) begin
          fenced[i] <= vld[i] && isWr[i] && inScope[i];
        end
      end
    end
  end
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import same_addr_gate_pkg::*;
#(
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              outReady,
  input  logic              full,
  input  logic              wrHit,
  input  logic [CHAN_W-1:0] wrHitChan,
  input  logic              rdHit,
  input  logic              rdConflict,
  input  logic              fenceBusy,
  input  logic              fenceBlock,
  output logic              reqReady,
  output logic              outValid,
  output logic [CHAN_W-1:0] effChan,
  output gateStrobe_t       strobe
);
  logic              holdValid;
  logic [CHAN_W-1:0] holdChan;
  logic              stall, accept;

  assign effChan = holdValid ? holdChan : reqChan;

  always_comb begin
    unique case (reqKind)
      KIND_READ:  stall = full || wrHit || rdConflict;
      KIND_WRITE: stall = full || wrHit || rdHit || fenceBlock;
      KIND_FENCE: stall = fenceBusy;
      default:    stall = 1'b1;
    endcase
  end

  assign outValid        = reqValid && !stall;
  assign reqReady        = outReady && !stall;
  assign accept          = reqValid && reqReady;
  assign strobe.alloc    = accept && (reqKind != KIND_FENCE);
  assign strobe.armFence = accept && (reqKind == KIND_FENCE);

  // remember the channel of the write a held request waits on
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdChan  <= '0;
    end else if (reqValid && (reqKind != KIND_FENCE) && wrHit) begin
      holdValid <= 1'b1;
      holdChan  <= wrHitChan;
    end else if (accept) begin
      holdValid <= 1'b0;
    end
  end
endmodule

// File: rtl/same_addr_gate.sv
module same_addr_gate
  import same_addr_gate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int CHAN_W  = 2,
  parameter int TAG_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outKind,
  output logic [ADDR_W-1:0] outAddr,
  output logic [CHAN_W-1:0] outChan,
  output logic [TAG_W-1:0]  outTag,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag
);
  gateStrobe_t        strobe;
  logic               wrHit, rdHit, rdConflict, fenceBusy, fenceBlock, full;
  logic [CHAN_W-1:0]  wrHitChan, effChan;
  logic [ENTRIES-1:0] occupied;

  assign full    = &occupied;
  assign outKind = reqKind;
  assign outAddr = reqAddr;
  assign outTag  = reqTag;
  assign outChan = effChan;

  gate_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .TAG_W(TAG_W)) tbl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isWrite(reqKind == KIND_WRITE),
    .inAddr(reqAddr), .cmpChan(effChan), .inTag(reqTag),
    .rspValid(rspValid), .rspTag(rspTag),
    .wrHit(wrHit), .wrHitChan(wrHitChan), .rdHit(rdHit), .rdConflict(rdConflict),
    .fenceBusy(fenceBusy), .fenceBlock(fenceBlock), .occupied(occupied)
  );

  gate_ctrl #(.CHAN_W(CHAN_W)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqChan(reqChan),
    .outReady(outReady), .full(full), .wrHit(wrHit), .wrHitChan(wrHitChan),
    .rdHit(rdHit), .rdConflict(rdConflict), .fenceBusy(fenceBusy), .fenceBlock(fenceBlock),
    .reqReady(reqReady), .outValid(outValid), .effChan(effChan), .strobe(strobe)
  );
endmodule

// File: rtl/same_addr_gate_check.sv
module same_addr_gate_check
  import same_addr_gate_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               outValid,
  input logic               outReady,
  input logic [1:0]         outKind,
  input logic               rspValid,
  input logic               wrHit,
  input logic               rdHit,
  input logic               fenceBlock,
  input logic [ENTRIES-1:0] occupied
);
  a_r2_accept_issues: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (outValid && outReady));

  a_r3_write_not_over_write: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_WRITE) |-> !wrHit);

  a_r4_read_not_over_write: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_READ) |-> !wrHit);

  a_r5_write_not_over_read: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_WRITE) |-> !rdHit);

  a_r7_fence_holds_writes: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_WRITE) |-> !fenceBlock);

  a_r9_no_issue_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind != KIND_FENCE) |-> !(&occupied));

  a_r9_alloc_grows: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outKind != KIND_FENCE && !rspValid) |=>
      ($countones(occupied) == $past($countones(occupied)) + 1));
endmodule

bind same_addr_gate same_addr_gate_check #(.ENTRIES(ENTRIES)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .outValid(outValid), .outReady(outReady), .outKind(outKind), .rspValid(rspValid),
  .wrHit(wrHit), .rdHit(rdHit), .fenceBlock(fenceBlock), .occupied(occupied)
);

// File: tb/same_addr_gate_test.sv
module same_addr_gate_test;
  localparam int N = 16;
  localparam int ADDR_W = 26;
  localparam int CHAN_W = 2;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              reqValid = 1'b0, reqReady, outValid, outReady = 1'b0, rspValid = 1'b0;
  logic [1:0]        reqKind = '0, outKind;
  logic [ADDR_W-1:0] reqAddr = '0, outAddr;
  logic [CHAN_W-1:0] reqChan = '0, outChan;
  logic [TAG_W-1:0]  reqTag = '0, outTag, rspTag = '0;

  same_addr_gate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqChan(reqChan), .reqTag(reqTag), .outValid(outValid),
    .outReady(outReady), .outKind(outKind), .outAddr(outAddr), .outChan(outChan),
    .outTag(outTag), .rspValid(rspValid), .rspTag(rspTag)
  );

  int errors = 0, checks = 0;
  bit mV[N], mW[N], mF[N];
  int mA[N], mC[N], mT[N];
  bit holdV = 0;
  int holdC = 0, fChan = 0;
  bit pStall, pWrHit;
  int pWrChan, pChan;
  string pTag;
  bit lastAcc;
  int lastChan;
  int tagCnt = 0;

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic bit overlap(int a, int b);
    return (a == 0) || (b == 0) || (a == b);
  endfunction

  function automatic bit tagUsed(int t);
    for (int i = 0; i < N; i++) if (mV[i] && mT[i] == t) return 1;
    return 0;
  endfunction

  // expected stall, issue channel and responsible requirement
  function automatic void predict(int k, int a, int c);
    int cnt = 0;
    bit wr = 0, rd = 0, rc = 0, fbusy = 0, fb;
    pChan = holdV ? holdC : c;
    pWrChan = 0;
    for (int i = 0; i < N; i++) if (mV[i]) begin
      cnt++;
      if (mF[i]) fbusy = 1;
      if (mA[i] == a) begin
        if (mW[i]) begin wr = 1; pWrChan = mC[i]; end
        else begin rd = 1; if (mC[i] != pChan || pChan == 0) rc = 1; end
      end
    end
    fb = fbusy && overlap(fChan, pChan);
    pWrHit = wr && (k != 2);
    pStall = 0; pTag = "R2";
    if (k == 2) begin
      if (fbusy) begin pStall = 1; pTag = "R11"; end
    end else if (cnt == N) begin pStall = 1; pTag = "R9"; end
    else if (k == 1 && fb) begin pStall = 1; pTag = (fChan == 0) ? "R7" : "R8"; end
    else if (wr) begin pStall = 1; pTag = (k == 1) ? "R3" : "R4"; end
    else if (k == 1 && rd) begin pStall = 1; pTag = "R5"; end
    else if (k == 0 && rc) begin pStall = 1; pTag = "R6"; end
  endfunction

  task automatic step(bit v, int k, int a, int c, int t, bit rv, int rt, bit ordy);
    bit expOut;
    @(negedge clk);
    reqValid = v; reqKind = 2'(k); reqAddr = ADDR_W'(a); reqChan = CHAN_W'(c);
    reqTag = TAG_W'(t); rspValid = rv; rspTag = TAG_W'(rt); outReady = ordy;
    #1;
    predict(k, a, c);
    expOut = v && !pStall;
    chk(outValid == expOut, pTag, int'(outValid), int'(expOut));
    chk(reqReady == (ordy && !pStall), pTag, int'(reqReady), int'(ordy && !pStall));
    if (expOut) begin
      chk(outChan == CHAN_W'(pChan), holdV ? ((k == 1) ? "R3" : "R4") : "R2",
          int'(outChan), pChan);
      chk(outAddr == ADDR_W'(a) && outTag == TAG_W'(t) && outKind == 2'(k), "R2",
          int'(outTag), t);
    end
    lastAcc = v && !pStall && ordy;
    lastChan = int'(outChan);
    @(posedge clk);
    if (rv) for (int i = 0; i < N; i++)
      if (mV[i] && mT[i] == rt) begin mV[i] = 0; mF[i] = 0; end
    if (v && pWrHit) begin holdV = 1; holdC = pWrChan; end
    else if (lastAcc) holdV = 0;
    if (lastAcc && k != 2) begin
      for (int i = 0; i < N; i++) if (!mV[i]) begin
        mV[i] = 1; mW[i] = (k == 1); mA[i] = a; mC[i] = pChan; mT[i] = t; mF[i] = 0;
        break;
      end
    end
    if (lastAcc && k == 2) begin
      fChan = pChan;
      for (int i = 0; i < N; i++)
        if (mV[i] && mW[i] && overlap(fChan, mC[i])) mF[i] = 1;
    end
  endtask

  task automatic issue(int k, int a, int c, int t);
    for (int n = 0; n < 30; n++) begin
      step(1, k, a, c, t, 0, 0, 1);
      if (lastAcc) break;
    end
    chk(lastAcc, "R2", int'(lastAcc), 1);
  endtask

  task automatic drain();
    for (int n = 0; n < 40; n++) begin
      int rt = -1;
      for (int i = 0; i < N; i++) if (mV[i] && rt < 0) rt = mT[i];
      if (rt < 0) break;
      step(0, 0, 0, 0, 0, 1, rt, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; outReady = 1'b1;
    #1;
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(reqReady == 1'b1, "R1", int'(reqReady), 1);

    // R3: write over write, redirected to first write's channel
    issue(1, 10, 1, 1);
    step(1, 1, 10, 2, 2, 0, 0, 1); chk(!lastAcc, "R3", int'(lastAcc), 0);
    step(1, 1, 10, 2, 2, 1, 1, 1); chk(!lastAcc, "R10", int'(lastAcc), 0);
    step(1, 1, 10, 2, 2, 0, 0, 1); chk(lastAcc, "R10", int'(lastAcc), 1);
    chk(lastChan == 1, "R3", lastChan, 1);
    drain();
    // R4: read over write
    issue(1, 42, 3, 50);
    step(1, 0, 42, 1, 51, 0, 0, 1); chk(!lastAcc, "R4", int'(lastAcc), 0);
    step(1, 0, 42, 1, 51, 1, 50, 1);
    step(1, 0, 42, 1, 51, 0, 0, 1); chk(lastAcc && lastChan == 3, "R4", lastChan, 3);
    drain();
    // R5: write over read keeps own channel
    issue(0, 41, 2, 40);
    step(1, 1, 41, 3, 41, 0, 0, 1); chk(!lastAcc, "R5", int'(lastAcc), 0);
    step(1, 1, 41, 3, 41, 1, 40, 1);
    step(1, 1, 41, 3, 41, 0, 0, 1); chk(lastAcc && lastChan == 3, "R5", lastChan, 3);
    drain();
    // R6: read after read
    issue(0, 40, 1, 30);
    step(1, 0, 40, 1, 31, 0, 0, 1); chk(lastAcc, "R6", int'(lastAcc), 1);
    step(1, 0, 40, 2, 32, 0, 0, 1); chk(!lastAcc, "R6", int'(lastAcc), 0);
    drain();
    issue(0, 40, 0, 33);
    step(1, 0, 40, 0, 34, 0, 0, 1); chk(!lastAcc, "R6", int'(lastAcc), 0);
    drain();
    // R7 and R11: auto-select fence
    issue(1, 20, 1, 10); issue(1, 21, 2, 11); issue(2, 0, 0, 12);
    step(1, 0, 22, 1, 13, 0, 0, 1); chk(lastAcc, "R7", int'(lastAcc), 1);
    step(1, 1, 23, 3, 14, 1, 10, 1); chk(!lastAcc, "R7", int'(lastAcc), 0);
    step(1, 1, 23, 3, 14, 0, 0, 1); chk(!lastAcc, "R7", int'(lastAcc), 0);
    step(1, 1, 23, 3, 14, 1, 11, 1); chk(!lastAcc, "R10", int'(lastAcc), 0);
    step(1, 1, 23, 3, 14, 0, 0, 1); chk(lastAcc, "R7", int'(lastAcc), 1);
    issue(1, 24, 1, 15); issue(2, 0, 0, 16);
    step(1, 2, 0, 0, 17, 0, 0, 1); chk(!lastAcc, "R11", int'(lastAcc), 0);
    drain();
    // R8: channel-scoped fence
    issue(1, 30, 1, 20); issue(2, 0, 1, 21);
    step(1, 1, 31, 2, 22, 0, 0, 1); chk(lastAcc, "R8", int'(lastAcc), 1);
    step(1, 1, 32, 1, 23, 0, 0, 1); chk(!lastAcc, "R8", int'(lastAcc), 0);
    drain();
    // R9: full table
    for (int i = 0; i < N; i++) issue(1, 100 + i, 1, 200 + i);
    step(1, 0, 50, 1, 230, 0, 0, 1); chk(!lastAcc, "R9", int'(lastAcc), 0);
    step(1, 0, 50, 1, 230, 1, 200, 1); chk(!lastAcc, "R9", int'(lastAcc), 0);
    step(1, 0, 50, 1, 230, 0, 0, 1); chk(lastAcc, "R9", int'(lastAcc), 1);
    drain();

    // random traffic on four lines
    begin
      bit curV = 0;
      int curK = 0, curA = 0, curC = 0, curT = 0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
        bit rv = 0;
        int rt = 0;
        if (!curV && ($urandom % 4) != 0) begin
          int r = $urandom % 16;
          curK = (r < 1) ? 2 : ((r < 8) ? 0 : 1);
          curA = $urandom % 4;
          curC = $urandom % 4;
          do tagCnt = (tagCnt % 199) + 1; while (tagUsed(tagCnt));
          curT = tagCnt;
          curV = 1;
        end
        if (($urandom % 3) == 0) begin
          int s = $urandom % N;
          for (int j = 0; j < N; j++)
            if (!rv && mV[(s + j) % N]) begin rv = 1; rt = mT[(s + j) % N]; end
        end
        step(curV, curK, curA, curC, curT, rv, rt, ($urandom % 5) != 0);
        if (lastAcc) curV = 0;
      end
    end
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule